// File: doc/BRIEF.md
# Byte-Wide Stack Machine Core

A multicycle processor with an 8-bit datapath and a 16-bit byte address space. It fetches one-byte instructions, uses the low four bits of each as the opcode, and runs eleven operations: no-op, halt, push of an inline byte, push from an absolute address, discarding pop, pop to an absolute address, two conditional jumps, and add, subtract and NOR. No operand is named in the instruction. The operands sit on a stack held in memory, which grows toward lower addresses. The stack pointer always names the next free byte, so the top entry is at SP+1 and the entry beneath it is at SP+2.

The core uses one synchronous single-port byte memory. A read returns its data in the cycle after the address is presented. A write is performed when the address, data and write enable are all present at a clock edge. Each memory access therefore gets its own state in the controller, and every instruction takes a fixed number of cycles.

The zero and negative flags are brought out so that a status register can be built around the core. A stopped core reports its reason on two outputs: one for an executed halt and one for an illegal opcode. Both conditions hold until reset.

Top module: `stk8_core`

## Requirements
- R1: Reset is a synchronous active-high `rst`. While it is held, `mem_addr` is 0x0000, `mem_we` is 0, and `halted`, `faulted`, `flag_z` and `flag_n` are all 0. The first instruction after reset is fetched from address 0x0000. The stack pointer starts at 0xFFFA, so the first push writes address 0xFFFA.
- R2: Only bits 3:0 of an instruction byte select the operation; bits 7:4 are ignored. The encodings are: 0 no-op, 1 halt, 2 push inline byte, 3 push from address, 4 discarding pop, 5 pop to address, 6 jump if Z clear, 7 jump if N clear, 8 add, 9 subtract, 0xA NOR.
- R3: An opcode from 0xB to 0xF sets `faulted` two cycles after its fetch begins. From then until reset, no further memory write occurs and `mem_addr` stays at the address of the faulting byte.
- R4: Opcode 1 sets `halted`. From then until reset, there is no memory write, `mem_addr` stays at the byte after the halt, and the flags hold their values.
- R5: Opcode 2 writes the byte that follows the opcode to address SP and then decrements SP.
- R6: Opcodes 3, 5, 6 and 7 take a 16-bit address from the two bytes after the opcode, high byte first. Opcode 3 reads the byte at that address and pushes it the same way opcode 2 does.
- R7: Opcode 4 increments SP and writes nothing. Opcode 5 stores the top entry (SP+1) at the address operand and then increments SP.
- R8: Opcode 8 writes top + second to SP+2. Opcode 9 writes top − second to SP+2. Both increment SP, set Z when the 8-bit result is zero, and set N to bit 7 of the result.
- R9: Opcode 0xA writes NOT(top OR second) to SP+2 and increments SP. Z and N are left unchanged.
- R10: When the tested flag is clear, opcode 6 (tests Z) and opcode 7 (tests N) load PC with the address operand. Otherwise execution continues at the byte after the two address bytes.
- R11: Cycles per instruction, counted from the start of its fetch: opcodes 0, 1 and 4 take 2 cycles, opcode 2 takes 3, opcodes 6, 7, 8, 9 and 0xA take 4, and opcodes 3 and 5 take 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid the cycle after its address |
| halted | output | 1 | Halt instruction executed |
| faulted | output | 1 | Illegal opcode seen |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest cases to reach are the jump outcomes that depend on flags. The ports only set a flag as a side effect of an arithmetic result, so each jump test first pushes two chosen bytes and subtracts them, which puts Z or N into a known state. The test then places code on both the fall-through path and the target path, and each path leaves a different marker byte in memory. Nothing inside the core is observable, so every result is pulled back out through a pop to a fixed address and read from the bench memory. Stopped states are held for a further stretch of cycles while the bench watches for stray writes and a moving address.

// File: rtl/stk8_core.sv
`timescale 1ns/1ps
module stk8_core #(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] SP_RESET = 16'hFFFA
)(
  input  logic            clk,
  input  logic            rst,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  input  logic [DW-1:0]   mem_rdata,
  output logic            halted,
  output logic            faulted,
  output logic            flag_z,
  output logic            flag_n
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  localparam logic [3:0] OP_NOP = 4'h0, OP_HLT = 4'h1, OP_PSI = 4'h2, OP_PSX = 4'h3,
                         OP_POP = 4'h4, OP_PPX = 4'h5, OP_JZC = 4'h6, OP_JNC = 4'h7,
                         OP_ADD = 4'h8, OP_SUB = 4'h9, OP_NOR = 4'hA;

  typedef enum logic [3:0] {
    S_FETCH, S_DEC, S_XHI, S_XLO, S_WR, S_ALA, S_ALB, S_STOP
  } state_t;

  state_t          st;
  logic [AW-1:0]   pc, sp, mr;
  logic [3:0]      op;
  logic [DW-1:0]   alu_y;
  logic [3:0]      nib;
  logic            alu_nib;

  assign nib     = mem_rdata[3:0];
  assign alu_nib = (nib == OP_ADD) || (nib == OP_SUB) || (nib == OP_NOR);

  always_comb begin
    case (op)
      OP_ADD:  alu_y = mr[DW-1:0] + mem_rdata;
      OP_SUB:  alu_y = mr[DW-1:0] - mem_rdata;
      default: alu_y = ~(mr[DW-1:0] | mem_rdata);
    endcase
  end

  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = mem_rdata;
    case (st)
      S_DEC:  mem_addr = alu_nib ? sp + ONE : pc + ONE;
      S_XHI:  mem_addr = pc + ONE;
      S_XLO:  mem_addr = (op == OP_PPX) ? sp + ONE : {mr[AW-1:DW], mem_rdata};
      S_WR: begin
        mem_we   = 1'b1;
        mem_addr = (op == OP_PPX) ? mr : sp;
      end
      S_ALA:  mem_addr = sp + TWO;
      S_ALB: begin
        mem_we    = 1'b1;
        mem_addr  = sp + TWO;
        mem_wdata = alu_y;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_FETCH;
      pc      <= '0;
      sp      <= SP_RESET;
      mr      <= '0;
      op      <= OP_NOP;
      halted  <= 1'b0;
      faulted <= 1'b0;
      flag_z  <= 1'b0;
      flag_n  <= 1'b0;
    end else begin
      case (st)
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          op <= nib;
          if (nib > OP_NOR) begin
            faulted <= 1'b1;
            st      <= S_STOP;
          end else begin
            pc <= pc + ONE;
            case (nib)
              OP_NOP: st <= S_FETCH;
              OP_HLT: begin
                halted <= 1'b1;
                st     <= S_STOP;
              end
              OP_PSI: st <= S_WR;
              OP_POP: begin
                sp <= sp + ONE;
                st <= S_FETCH;
              end
              OP_ADD, OP_SUB, OP_NOR: st <= S_ALA;
              default: st <= S_XHI;
            endcase
          end
        end
        S_XHI: begin
          mr[AW-1:DW] <= mem_rdata;
          st          <= S_XLO;
        end
        S_XLO: begin
          mr[DW-1:0] <= mem_rdata;
          case (op)
            OP_JZC: begin
              pc <= !flag_z ? {mr[AW-1:DW], mem_rdata} : pc + TWO;
              st <= S_FETCH;
            end
            OP_JNC: begin
              pc <= !flag_n ? {mr[AW-1:DW], mem_rdata} : pc + TWO;
              st <= S_FETCH;
            end
            default: st <= S_WR;
          endcase
        end
        S_WR: begin
          sp <= (op == OP_PPX) ? sp + ONE : sp - ONE;
          pc <= pc + ((op == OP_PSI) ? ONE : TWO);
          st <= S_FETCH;
        end
        S_ALA: begin
          mr[DW-1:0] <= mem_rdata;
          st         <= S_ALB;
        end
        S_ALB: begin
          sp <= sp + ONE;
          if (op != OP_NOR) begin
            flag_z <= (alu_y == '0);
            flag_n <= alu_y[DW-1];
          end
          st <= S_FETCH;
        end
        default: st <= S_STOP;
      endcase
    end
  end

  a_r3_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    faulted |=> faulted);

  a_r4_stopped_no_write: assert property (@(posedge clk) disable iff (rst)
    (halted || faulted) |-> !mem_we);

  a_r4_stopped_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (halted || faulted) |=> $stable(mem_addr));

  a_r5_push_lowers_sp: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR && op != OP_PPX) |=> sp == $past(sp) - ONE);

  a_r9_nor_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (st == S_ALB && op == OP_NOR) |=> $stable({flag_z, flag_n}));

  a_r8_alu_writes_once: assert property (@(posedge clk) disable iff (rst)
    (st == S_ALB) |=> !mem_we);
endmodule

// File: tb/stk8_core_tb.sv
`timescale 1ns/1ps
module stk8_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic        halted, faulted, flag_z, flag_n;

  int checks = 0;
  int fails  = 0;
  int stray  = 0;
  logic [7:0] mem [0:4095];

  always #2.5 clk = ~clk;

  stk8_core dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .faulted(faulted), .flag_z(flag_z), .flag_n(flag_n)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
    if (!rst && (halted || faulted) && mem_we) stray++;
  end

  // op, top, second, result, {6'b0, z, n}
  localparam logic [39:0] VECS [8] = '{
    {8'h98, 8'h05, 8'h03, 8'h08, 8'h00},
    {8'h08, 8'h80, 8'h80, 8'h00, 8'h02},
    {8'h08, 8'h7F, 8'h01, 8'h80, 8'h01},
    {8'h09, 8'h03, 8'h05, 8'hFE, 8'h01},
    {8'h09, 8'h44, 8'h44, 8'h00, 8'h02},
    {8'h09, 8'h10, 8'h01, 8'h0F, 8'h00},
    {8'h0A, 8'hF0, 8'h0C, 8'h03, 8'h00},
    {8'h5A, 8'h00, 8'h00, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a[11:0]] <= b;
  endtask

  task automatic run(output int cyc);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!(halted || faulted) && cyc < 400) begin
      @(posedge clk);
      #1;
      cyc++;
    end
  endtask

  task automatic hold_check(input string req, input logic [15:0] addr);
    int s0;
    s0 = stray;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      #1;
      if (mem_addr !== addr) begin
        chk(req, mem_addr, addr);
        break;
      end
    end
    chk(req, stray - s0, 0);
  endtask

  task automatic jump_case(input string req, input logic [7:0] sec, input logic [7:0] top,
                           input logic [7:0] opc, input bit taken);
    int cyc;
    clr();
    put(0, 8'h02); put(1, sec); put(2, 8'h02); put(3, top); put(4, 8'h09);
    put(5, opc); put(6, 8'h00); put(7, 8'h20);
    put(8, 8'h02); put(9, 8'h77); put(10, 8'h05); put(11, 8'h08); put(12, 8'h40); put(13, 8'h01);
    put(32, 8'h02); put(33, 8'h99); put(34, 8'h05); put(35, 8'h08); put(36, 8'h40); put(37, 8'h01);
    run(cyc);
    chk(req, mem[12'h840], taken ? 8'h99 : 8'h77);
    chk({req, " R11"}, cyc, 24);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [39:0] v;

    // R8 R9 R2 R11: table walk
    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      clr();
      put(0, 8'h02); put(1, v[23:16]); put(2, 8'h02); put(3, v[31:24]);
      put(4, v[39:32]); put(5, 8'h05); put(6, 8'h08); put(7, 8'h00); put(8, 8'h01);
      run(cyc);
      chk("R8/R9 result", mem[12'h800], v[15:8]);
      chk("R8/R9 flags", {flag_z, flag_n}, v[1:0]);
      chk("R11 alu program cycles", cyc, 17);
    end

    // R1: reset state after a run that left Z set
    clr();
    put(0, 8'h02); put(1, 8'h44); put(2, 8'h02); put(3, 8'h44); put(4, 8'h09); put(5, 8'h01);
    run(cyc);
    chk("R1 precondition z", flag_z, 1'b1);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 addr", mem_addr, 16'h0000);
    chk("R1 we", mem_we, 1'b0);
    chk("R1 stop flags", {halted, faulted}, 2'b00);
    chk("R1 zn", {flag_z, flag_n}, 2'b00);

    // R1 R5: first push lands at 0xFFFA
    clr();
    put(0, 8'h02); put(1, 8'hAA); put(2, 8'h01);
    run(cyc);
    chk("R1 R5 push target", mem[12'hFFA], 8'hAA);
    chk("R11 push+halt cycles", cyc, 5);

    // R9: NOR keeps Z set by a prior add
    clr();
    put(0, 8'h02); put(1, 8'h80); put(2, 8'h02); put(3, 8'h80); put(4, 8'h08);
    put(5, 8'h02); put(6, 8'h0F); put(7, 8'h0A);
    put(8, 8'h05); put(9, 8'h08); put(10, 8'h50); put(11, 8'h01);
    run(cyc);
    chk("R9 nor result", mem[12'h850], 8'hF0);
    chk("R9 flags held", {flag_z, flag_n}, 2'b10);

    // R6: push from address, then pop to address
    clr();
    put(12'h812, 8'h5C);
    put(0, 8'h03); put(1, 8'h08); put(2, 8'h12);
    put(3, 8'h05); put(4, 8'h08); put(5, 8'h20); put(6, 8'h01);
    run(cyc);
    chk("R6 pushext", mem[12'h820], 8'h5C);
    chk("R11 pushext/popext cycles", cyc, 12);

    // R7: discarding pop exposes the entry below
    clr();
    put(0, 8'h02); put(1, 8'h11); put(2, 8'h02); put(3, 8'h22); put(4, 8'h04);
    put(5, 8'h05); put(6, 8'h08); put(7, 8'h30); put(8, 8'h01);
    run(cyc);
    chk("R7 pop discards top", mem[12'h830], 8'h11);
    chk("R11 pop cycles", cyc, 15);

    // R10: both jumps, taken and not taken
    jump_case("R10 jz-clear not taken", 8'h01, 8'h01, 8'h06, 1'b0);
    jump_case("R10 jz-clear taken", 8'h01, 8'h02, 8'h66, 1'b1);
    jump_case("R10 jn-clear not taken", 8'h05, 8'h03, 8'h07, 1'b0);
    jump_case("R10 jn-clear taken", 8'h03, 8'h05, 8'h07, 1'b1);

    // R2 R4: no-op with high bits, then halt holds still
    clr();
    put(0, 8'hF0); put(1, 8'h00); put(2, 8'h01);
    run(cyc);
    chk("R2 R11 noop cycles", cyc, 6);
    chk("R4 halted", {halted, faulted}, 2'b10);
    chk("R4 halt addr", mem_addr, 16'h0003);
    hold_check("R4 halt frozen", 16'h0003);

    // R3: illegal opcode, sticky until reset
    clr();
    put(0, 8'h02); put(1, 8'hAA); put(2, 8'h0B); put(3, 8'h02); put(4, 8'hBB); put(5, 8'h01);
    run(cyc);
    chk("R3 faulted", {halted, faulted}, 2'b01);
    chk("R3 fault cycle", cyc, 5);
    chk("R3 fault addr", mem_addr, 16'h0002);
    hold_check("R3 fault frozen", 16'h0002);
    chk("R3 no later push", mem[12'hFF9], 8'h00);
    chk("R3 still faulted", faulted, 1'b1);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R3 cleared by reset", faulted, 1'b0);

    clr();
    put(0, 8'hAF);
    run(cyc);
    chk("R3 opcode F faults", {faulted, 8'(cyc)}, {1'b1, 8'd2});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule